// File: doc/BRIEF.md
# Outstanding Miss Request Tracker

This block keeps track of cache-line requests that missed in the first-level cache and are waiting for the memory system, for several hardware threads at once. Every thread owns two small fully associative tables, one for reads and one for writes. Each table holds up to `DEPTH` entries keyed by line address, where the line address is the request address with its low `OFF_W` offset bits dropped. A request's kind decides which of the two tables it goes to. An entry records the kind, a software-prefetch flag and the cycle in which it was inserted, taken from an internal free-running cycle counter.

On the issue side the requester presents a request on a valid/ready port. The `adm_ok` output is a separate admission check: a requester that wants to stay within the tracker's limits issues only when it is high. The insert port does not itself refuse a request that fails the admission check. It accepts whenever the target table can take the request, either into a free slot or by overwriting the entry it already has for that line. Back-pressure on the insert port comes from two sources only. A completion in the same cycle takes priority, and a full target table that lacks the line refuses the request. The requester must hold valid and the request fields steady until ready is seen high. Completions are presented with a plain strobe and are always accepted. The resulting hit response and error pulse are single-cycle outputs with no back-pressure.

A periodic age watchdog arms itself on an insert and scans all entries once per threshold interval. It raises a sticky stall flag if any entry has become too old.

Top module: `mt_miss_tracker`

## Requirements
- R1: Kind codes 3 (store), 4 (transactional store), 5 (transactional exclusive load) and 6 (atomic) are placed in the write table. Codes 0 (load), 1 (instruction fetch), 2 (transactional load) and the spare code 7 are placed in the read table. A completion reaches only the table named by `cpl_write`.
- R2: `adm_ok` is low whenever `out_count` is at or above `MAX_OUT`.
- R3: `adm_ok` is low whenever any thread holds a read or write entry for the line of `req_addr`. Offset bits below `OFF_W` take no part in any address match.
- R4: A request accepted for a line that its thread already holds in the same-kind table overwrites that entry's kind, prefetch flag and insert time. It does not change `out_count`, and `req_dup` pulses high in the following cycle.
- R5: `req_ready` is low while `cpl_valid` is high. It is also low when the target table neither holds the line nor has a free slot; otherwise it is high.
- R6: A completion removes one matching entry from the selected table kind. Among the threads that match, it takes the one whose entry is oldest, and on equal age it takes the lowest thread index.
- R7: `out_count` rises by one for each new entry and falls by one for each removal, and it always equals the number of valid entries. `prefetch_count` counts the valid entries flagged as prefetch, and `demand_count` counts the remaining valid entries.
- R8: One cycle after a completion that removes a demand entry, `hit_valid` pulses with the thread, the kind and `hit_lat`. `hit_lat` is the number of cycles between the insert (or the last time refresh) and the completion. A completion that removes a prefetch entry produces no hit pulse.
- R9: A completion that matches no entry raises `cpl_err` for one cycle and leaves all state unchanged.
- R10: A time refresh (`ts_valid`, with `ts_rd` and/or `ts_wr`) sets the insert time of that thread's matching read and/or write entry to the current cycle.
- R11: The watchdog arms on an insert while disarmed. Every `THRESH` cycles after arming it scans the entries. After a scan it re-arms if entries remain, and it disarms if the tracker is empty. `wd_armed` shows whether it is armed.
- R12: A scan that finds a valid entry aged `THRESH` cycles or more sets `stall_flag`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Insert request valid |
| req_ready | output | 1 | Insert request accepted this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 3 | Request kind code |
| req_tid | input | TID_W | Issuing thread |
| req_pf | input | 1 | Software prefetch flag |
| adm_ok | output | 1 | Admission check result for the presented request |
| req_dup | output | 1 | Previous accepted insert overwrote an existing entry |
| cpl_valid | input | 1 | Completion strobe |
| cpl_write | input | 1 | Completion targets write tables (1) or read tables (0) |
| cpl_addr | input | ADDR_W | Completion address |
| hit_valid | output | 1 | Demand hit response |
| hit_tid | output | TID_W | Thread of the hit response |
| hit_kind | output | 3 | Kind of the completed request |
| hit_lat | output | TS_W | Miss latency in cycles |
| cpl_err | output | 1 | Completion matched no entry |
| ts_valid | input | 1 | Time refresh strobe |
| ts_tid | input | TID_W | Thread for time refresh |
| ts_addr | input | ADDR_W | Address for time refresh |
| ts_rd | input | 1 | Refresh the read entry |
| ts_wr | input | 1 | Refresh the write entry |
| out_count | output | CNT_W | Outstanding entries |
| demand_count | output | CNT_W | Outstanding demand entries |
| prefetch_count | output | CNT_W | Outstanding prefetch entries |
| wd_armed | output | 1 | Watchdog armed |
| stall_flag | output | 1 | Sticky stall indication |

## Verification
The properties assume that the requester never sees an insert and a completion accepted in the same cycle. The block guarantees this by dropping `req_ready` under `cpl_valid`. They also assume that completions may name absent lines, so error cycles must leave the count untouched. The stimulus drives every input away from the clock edge and holds a request for exactly one cycle. It uses a small pool of eight lines across both threads, so that duplicates, cross-thread collisions, full tables and missing lines all occur often. Directed cases first pin down age ordering, time refresh and the watchdog period, and random traffic follows.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [2:0] {
    RQ_LOAD     = 3'd0,
    RQ_IFETCH   = 3'd1,
    RQ_LOAD_TX  = 3'd2,
    RQ_STORE    = 3'd3,
    RQ_STORE_TX = 3'd4,
    RQ_LOADX_TX = 3'd5,
    RQ_ATOMIC   = 3'd6,
    RQ_SPARE    = 3'd7
  } rq_kind_e;

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k >= RQ_STORE) && (k <= RQ_ATOMIC);
  endfunction
endpackage

// File: rtl/mt_line_table.sv
module mt_line_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 12,
  parameter int TS_W   = 16,
  parameter int THRESH = 64,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   now,
  input  logic [LINE_W-1:0] ins_line,
  input  logic              ins_en,
  input  logic [2:0]        ins_kind,
  input  logic              ins_pf,
  input  logic [LINE_W-1:0] cpl_line,
  input  logic              del_en,
  input  logic [LINE_W-1:0] ts_line,
  input  logic              ts_en,
  output logic              ins_hit,
  output logic              has_free,
  output logic              cpl_hit,
  output logic [TS_W-1:0]   cpl_stamp,
  output logic [2:0]        cpl_kind,
  output logic              cpl_pf,
  output logic              any_old,
  output logic [CNT_W-1:0]  n_vld,
  output logic [CNT_W-1:0]  n_pf
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] line_q  [DEPTH];
  logic [2:0]        kind_q  [DEPTH];
  logic              pf_q    [DEPTH];
  logic [TS_W-1:0]   stamp_q [DEPTH];

  logic [IDX_W-1:0] ins_idx, free_idx, cpl_idx, ts_idx;
  logic             ts_hit;

  // parallel compare of the three lookup ports against every entry
  always_comb begin
    ins_hit  = 1'b0;
    ins_idx  = '0;
    cpl_hit  = 1'b0;
    cpl_idx  = '0;
    ts_hit   = 1'b0;
    ts_idx   = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && line_q[i] == ins_line) begin
        ins_hit = 1'b1;
        ins_idx = IDX_W'(i);
      end
      if (vld_q[i] && line_q[i] == cpl_line) begin
        cpl_hit = 1'b1;
        cpl_idx = IDX_W'(i);
      end
      if (vld_q[i] && line_q[i] == ts_line) begin
        ts_hit = 1'b1;
        ts_idx = IDX_W'(i);
      end
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign cpl_stamp = stamp_q[cpl_idx];
  assign cpl_kind  = kind_q[cpl_idx];
  assign cpl_pf    = pf_q[cpl_idx];

  always_comb begin
    any_old = 1'b0;
    n_vld   = '0;
    n_pf    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i]) begin
        n_vld = n_vld + CNT_W'(1);
        if (pf_q[i]) n_pf = n_pf + CNT_W'(1);
        if (TS_W'(now - stamp_q[i]) >= TS_W'(THRESH)) any_old = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (ins_en && !ins_hit && has_free) vld_q[free_idx] <= 1'b1;
      if (del_en && cpl_hit) vld_q[cpl_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ts_en && ts_hit) stamp_q[ts_idx] <= now;
    if (ins_en) begin
      if (ins_hit) begin
        kind_q[ins_idx]  <= ins_kind;
        pf_q[ins_idx]    <= ins_pf;
        stamp_q[ins_idx] <= now;
      end else if (has_free) begin
        line_q[free_idx]  <= ins_line;
        kind_q[free_idx]  <= ins_kind;
        pf_q[free_idx]    <= ins_pf;
        stamp_q[free_idx] <= now;
      end
    end
  end
endmodule

// File: rtl/mt_oldest_pick.sv
module mt_oldest_pick #(
  parameter int NTHR  = 2,
  parameter int TS_W  = 16,
  parameter int TID_W = 1
) (
  input  logic [TS_W-1:0]  now,
  input  logic [NTHR-1:0]  hit,
  input  logic [TS_W-1:0]  stamp [NTHR],
  output logic             any,
  output logic [TID_W-1:0] sel
);
  logic [TS_W-1:0] best_age;
  logic [TS_W-1:0] age_t;

  // strict compare keeps the lowest thread index on equal age
  always_comb begin
    any      = 1'b0;
    sel      = '0;
    best_age = '0;
    age_t    = '0;
    for (int t = 0; t < NTHR; t++) begin
      age_t = now - stamp[t];
      if (hit[t] && (!any || age_t > best_age)) begin
        any      = 1'b1;
        sel      = TID_W'(t);
        best_age = age_t;
      end
    end
  end
endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog #(
  parameter int THRESH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_evt,
  input  logic busy,
  input  logic any_old,
  output logic armed,
  output logic stall
);
  localparam int WD_W = $clog2(THRESH + 1);

  logic [WD_W-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      stall  <= 1'b0;
      tick_q <= '0;
    end else if (!armed) begin
      if (arm_evt) begin
        armed  <= 1'b1;
        tick_q <= '0;
      end
    end else if (tick_q == WD_W'(THRESH - 1)) begin
      if (any_old) stall <= 1'b1;
      tick_q <= '0;
      if (!busy && !arm_evt) armed <= 1'b0;
    end else begin
      tick_q <= tick_q + WD_W'(1);
    end
  end
endmodule

// File: rtl/mt_miss_tracker.sv
module mt_miss_tracker
  import mt_pkg::*;
#(
  parameter int NTHR    = 2,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int TS_W    = 16,
  parameter int MAX_OUT = 6,
  parameter int THRESH  = 64,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int NTAB   = 2 * NTHR,
  localparam int CNT_W  = $clog2(NTAB * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_kind,
  input  logic [TID_W-1:0]  req_tid,
  input  logic              req_pf,
  output logic              adm_ok,
  output logic              req_dup,
  input  logic              cpl_valid,
  input  logic              cpl_write,
  input  logic [ADDR_W-1:0] cpl_addr,
  output logic              hit_valid,
  output logic [TID_W-1:0]  hit_tid,
  output logic [2:0]        hit_kind,
  output logic [TS_W-1:0]   hit_lat,
  output logic              cpl_err,
  input  logic              ts_valid,
  input  logic [TID_W-1:0]  ts_tid,
  input  logic [ADDR_W-1:0] ts_addr,
  input  logic              ts_rd,
  input  logic              ts_wr,
  output logic [CNT_W-1:0]  out_count,
  output logic [CNT_W-1:0]  demand_count,
  output logic [CNT_W-1:0]  prefetch_count,
  output logic              wd_armed,
  output logic              stall_flag
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int KW     = $clog2(NTAB);

  logic [TS_W-1:0]   now_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] req_line, cpl_line, ts_line;
  logic              req_wr, req_fire;
  logic [KW-1:0]     tgt_k, sel_k;
  logic              tgt_hit, tgt_free;

  logic [NTAB-1:0]   t_ins_hit, t_free, t_cpl_hit, t_pf, t_old;
  logic [TS_W-1:0]   t_stamp [NTAB];
  logic [2:0]        t_kind  [NTAB];
  logic [CNT_W-1:0]  t_nvld  [NTAB];
  logic [CNT_W-1:0]  t_npf   [NTAB];

  logic [NTHR-1:0]   pk_hit;
  logic [TS_W-1:0]   pk_stamp [NTHR];
  logic              pick_any;
  logic [TID_W-1:0]  pick_sel;

  logic [CNT_W-1:0]  vld_total, pf_total;

  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign cpl_line = cpl_addr[ADDR_W-1:OFF_W];
  assign ts_line  = ts_addr[ADDR_W-1:OFF_W];
  assign req_wr   = kind_is_write(req_kind);
  assign tgt_k    = KW'(2 * int'(req_tid) + int'(req_wr));
  assign sel_k    = KW'(2 * int'(pick_sel) + int'(cpl_write));
  assign tgt_hit  = t_ins_hit[tgt_k];
  assign tgt_free = t_free[tgt_k];

  assign req_ready = !cpl_valid && (tgt_hit || tgt_free);
  assign req_fire  = req_valid && req_ready;
  assign adm_ok    = (cnt_q < CNT_W'(MAX_OUT)) && !(|t_ins_hit);

  // table k serves thread k/2; odd k holds writes, even k holds reads
  for (genvar k = 0; k < NTAB; k++) begin : g_tab
    localparam int   TT = k / 2;
    localparam logic WW = ((k % 2) == 1);
    logic ins_en, del_en, ts_en;

    assign ins_en = req_fire && (int'(req_tid) == TT) && (req_wr == WW);
    assign del_en = cpl_valid && pick_any && (cpl_write == WW) && (int'(pick_sel) == TT);
    assign ts_en  = ts_valid && (int'(ts_tid) == TT) && (WW ? ts_wr : ts_rd);

    mt_line_table #(
      .DEPTH(DEPTH), .LINE_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH), .CNT_W(CNT_W)
    ) u_tab (
      .clk(clk), .rst_n(rst_n), .now(now_q),
      .ins_line(req_line), .ins_en(ins_en), .ins_kind(req_kind), .ins_pf(req_pf),
      .cpl_line(cpl_line), .del_en(del_en),
      .ts_line(ts_line), .ts_en(ts_en),
      .ins_hit(t_ins_hit[k]), .has_free(t_free[k]),
      .cpl_hit(t_cpl_hit[k]), .cpl_stamp(t_stamp[k]), .cpl_kind(t_kind[k]),
      .cpl_pf(t_pf[k]), .any_old(t_old[k]),
      .n_vld(t_nvld[k]), .n_pf(t_npf[k])
    );
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign pk_hit[t]   = cpl_write ? t_cpl_hit[2*t+1] : t_cpl_hit[2*t];
    assign pk_stamp[t] = cpl_write ? t_stamp[2*t+1]   : t_stamp[2*t];
  end

  mt_oldest_pick #(.NTHR(NTHR), .TS_W(TS_W), .TID_W(TID_W)) u_pick (
    .now(now_q), .hit(pk_hit), .stamp(pk_stamp), .any(pick_any), .sel(pick_sel)
  );

  mt_watchdog #(.THRESH(THRESH)) u_wd (
    .clk(clk), .rst_n(rst_n), .arm_evt(req_fire), .busy(cnt_q != '0),
    .any_old(|t_old), .armed(wd_armed), .stall(stall_flag)
  );

  always_comb begin
    vld_total = '0;
    pf_total  = '0;
    for (int k = 0; k < NTAB; k++) begin
      vld_total = vld_total + t_nvld[k];
      pf_total  = pf_total + t_npf[k];
    end
  end

  assign out_count      = cnt_q;
  assign prefetch_count = pf_total;
  assign demand_count   = vld_total - pf_total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q     <= '0;
      cnt_q     <= '0;
      req_dup   <= 1'b0;
      hit_valid <= 1'b0;
      hit_tid   <= '0;
      hit_kind  <= '0;
      hit_lat   <= '0;
      cpl_err   <= 1'b0;
    end else begin
      now_q     <= now_q + TS_W'(1);
      req_dup   <= req_fire && tgt_hit;
      hit_valid <= cpl_valid && pick_any && !t_pf[sel_k];
      cpl_err   <= cpl_valid && !pick_any;
      if (cpl_valid && pick_any) begin
        hit_tid  <= pick_sel;
        hit_kind <= t_kind[sel_k];
        hit_lat  <= now_q - t_stamp[sel_k];
      end
      if (req_fire && !tgt_hit)      cnt_q <= cnt_q + CNT_W'(1);
      else if (cpl_valid && pick_any) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/mt_tracker_chk.sv
module mt_tracker_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpl_valid,
  input logic             req_ready,
  input logic             req_dup,
  input logic             hit_valid,
  input logic             cpl_err,
  input logic             stall_flag,
  input logic [CNT_W-1:0] out_count,
  input logic [CNT_W-1:0] demand_count,
  input logic [CNT_W-1:0] prefetch_count,
  input logic [CNT_W-1:0] vld_total
);
  // R7
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_count == vld_total);
  // R7
  count_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(demand_count + prefetch_count) == out_count);
  // R5
  cpl_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !req_ready);
  // R4
  dup_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_dup |-> out_count == $past(out_count));
  // R9
  err_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_err |-> out_count == $past(out_count));
  // R8
  err_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_err |-> !hit_valid);
  // R12
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stall_flag) |-> stall_flag);
endmodule

bind mt_miss_tracker mt_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .req_ready(req_ready),
  .req_dup(req_dup), .hit_valid(hit_valid), .cpl_err(cpl_err),
  .stall_flag(stall_flag), .out_count(out_count), .demand_count(demand_count),
  .prefetch_count(prefetch_count), .vld_total(vld_total)
);

// File: tb/test_mt_miss_tracker.sv
module test_mt_miss_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, DP = 4, MAXO = 6, THR = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_pf = 0, cpl_valid = 0, cpl_write = 0;
  logic ts_valid = 0, ts_rd = 0, ts_wr = 0;
  logic [15:0] req_addr = '0, cpl_addr = '0, ts_addr = '0;
  logic [2:0]  req_kind = '0;
  logic        req_tid = 0, ts_tid = 0;
  logic req_ready, adm_ok, req_dup, hit_valid, cpl_err, wd_armed, stall_flag;
  logic hit_tid;
  logic [2:0] hit_kind;
  logic [15:0] hit_lat;
  logic [4:0] out_count, demand_count, prefetch_count;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit m_v [4][DP];
  bit m_pf [4][DP];
  int m_line [4][DP];
  int m_kind [4][DP];
  int m_st [4][DP];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  mt_miss_tracker i_mt_miss_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_tid(req_tid), .req_pf(req_pf),
    .adm_ok(adm_ok), .req_dup(req_dup), .cpl_valid(cpl_valid), .cpl_write(cpl_write),
    .cpl_addr(cpl_addr), .hit_valid(hit_valid), .hit_tid(hit_tid), .hit_kind(hit_kind),
    .hit_lat(hit_lat), .cpl_err(cpl_err), .ts_valid(ts_valid), .ts_tid(ts_tid),
    .ts_addr(ts_addr), .ts_rd(ts_rd), .ts_wr(ts_wr), .out_count(out_count),
    .demand_count(demand_count), .prefetch_count(prefetch_count),
    .wd_armed(wd_armed), .stall_flag(stall_flag)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit iswr(int kind);
    return kind >= 3 && kind <= 6;
  endfunction
  function automatic int mfind(int k, int line);
    for (int i = 0; i < DP; i++) if (m_v[k][i] && m_line[k][i] == line) return i;
    return -1;
  endfunction
  function automatic int mfree(int k);
    for (int i = 0; i < DP; i++) if (!m_v[k][i]) return i;
    return -1;
  endfunction
  function automatic int mcount(bit pf_only);
    int n = 0;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < DP; i++) if (m_v[k][i] && (!pf_only || m_pf[k][i])) n++;
    return n;
  endfunction
  function automatic bit manyline(int line);
    for (int k = 0; k < 4; k++) if (mfind(k, line) >= 0) return 1;
    return 0;
  endfunction

  task automatic chk_counts(string tag);
    chk({tag, " R7 out_count"}, int'(out_count), mcount(0));
    chk({tag, " R7 prefetch_count"}, int'(prefetch_count), mcount(1));
    chk({tag, " R7 demand_count"}, int'(demand_count), mcount(0) - mcount(1));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 4; k++) for (int i = 0; i < DP; i++) m_v[k][i] = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // starts and ends just after a falling edge
  task automatic do_ins(int t, int kind, int addr, bit pf, int exp_adm = -1);
    int k, line, h, f, st;
    bit rdy, adm;
    k = t * 2 + int'(iswr(kind));
    line = addr >> 4;
    h = mfind(k, line);
    f = mfree(k);
    req_valid = 1; req_tid = t[0]; req_kind = kind[2:0]; req_addr = addr[15:0]; req_pf = pf;
    #1;
    rdy = (h >= 0) || (f >= 0);
    adm = (mcount(0) < MAXO) && !manyline(line);
    chk("R5 req_ready", int'(req_ready), int'(rdy));
    chk("R2/R3 adm_ok", int'(adm_ok), int'(adm));
    if (exp_adm >= 0) chk("R2/R3 adm_ok directed", int'(adm_ok), exp_adm);
    st = cyc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (rdy) begin
      int s = (h >= 0) ? h : f;
      m_v[k][s] = 1; m_line[k][s] = line; m_kind[k][s] = kind; m_pf[k][s] = pf; m_st[k][s] = st;
    end
    chk("R4 req_dup", int'(req_dup), int'(rdy && h >= 0));
    chk_counts("ins");
  endtask

  task automatic do_cpl(bit w, int addr);
    int line, bt, bi, bage, st;
    line = addr >> 4;
    bt = -1; bi = -1; bage = 0;
    cpl_valid = 1; cpl_write = w; cpl_addr = addr[15:0];
    #1;
    chk("R5 ready low under completion", int'(req_ready), 0);
    st = cyc;
    for (int t = 0; t < NT; t++) begin
      int i = mfind(t * 2 + int'(w), line);
      if (i >= 0 && (bt < 0 || st - m_st[t*2+int'(w)][i] > bage)) begin
        bt = t; bi = i; bage = st - m_st[t*2+int'(w)][i];
      end
    end
    @(posedge clk);
    @(negedge clk);
    cpl_valid = 0;
    if (bt < 0) begin
      chk("R9 cpl_err", int'(cpl_err), 1);
      chk("R9 no hit", int'(hit_valid), 0);
    end else begin
      int k = bt * 2 + int'(w);
      chk("R9 no error", int'(cpl_err), 0);
      chk("R8 hit_valid", int'(hit_valid), int'(!m_pf[k][bi]));
      if (!m_pf[k][bi]) begin
        chk("R6 hit_tid", int'(hit_tid), bt);
        chk("R1 hit_kind", int'(hit_kind), m_kind[k][bi]);
        chk("R8/R10 hit_lat", int'(hit_lat), bage);
      end
      m_v[k][bi] = 0;
    end
    chk_counts("cpl");
  endtask

  task automatic do_ts(int t, int addr, bit rd, bit wr);
    int st = cyc;
    ts_valid = 1; ts_tid = t[0]; ts_addr = addr[15:0]; ts_rd = rd; ts_wr = wr;
    @(posedge clk);
    @(negedge clk);
    ts_valid = 0;
    for (int w = 0; w < 2; w++) begin
      int i = mfind(t * 2 + w, addr >> 4);
      if (i >= 0 && ((w == 0 && rd) || (w == 1 && wr))) m_st[t*2+w][i] = st;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got 0 expected 1 (run hung)");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    chk("R7 reset out_count", int'(out_count), 0);
    chk("R11 reset armed", int'(wd_armed), 0);
    chk("R12 reset stall", int'(stall_flag), 0);
    chk("R8 reset hit", int'(hit_valid), 0);

    // watchdog: arming, quiet disarm, then an aged entry
    do_ins(0, 0, 16'h0100, 0);
    chk("R11 armed after insert", int'(wd_armed), 1);
    idle(3);
    do_cpl(0, 16'h0100);
    idle(THR + 4);
    chk("R11 disarmed when empty", int'(wd_armed), 0);
    chk("R12 no stall", int'(stall_flag), 0);
    do_ins(1, 3, 16'h0200, 0);
    idle(THR + 4);
    chk("R12 stall raised", int'(stall_flag), 1);
    chk("R11 stays armed while busy", int'(wd_armed), 1);
    do_cpl(1, 16'h0200);
    idle(THR + 4);
    chk("R12 stall sticky", int'(stall_flag), 1);
    do_reset();

    // routing by kind and offset masking
    do_ins(0, 6, 16'h0300, 0);
    do_cpl(0, 16'h0300);            // R1: wrong table -> error
    do_cpl(1, 16'h0305);            // R1: write table hit, offset ignored
    do_ins(1, 7, 16'h0310, 0);
    do_cpl(0, 16'h0310);            // R1: spare code goes to read table

    // cross-thread same line and oldest pick
    do_ins(1, 1, 16'h0400, 0);
    idle(2);
    do_ins(0, 0, 16'h0408, 0, 0);   // R3 refused by admission, still inserted
    do_cpl(0, 16'h0400);            // R6 older thread 1 first
    do_cpl(0, 16'h0400);            // R6 then thread 0

    // overwrite turns a prefetch into a demand
    do_ins(0, 0, 16'h0600, 1);
    do_ins(0, 2, 16'h0600, 0);      // R4
    do_cpl(0, 16'h0600);

    // silent prefetch
    do_ins(1, 0, 16'h0700, 1);
    do_cpl(0, 16'h0700);            // R8 no hit pulse

    // timestamp refresh
    do_ins(0, 3, 16'h0800, 0);
    idle(10);
    do_ts(0, 16'h0800, 0, 1);       // R10
    idle(2);
    do_cpl(1, 16'h0800);

    // limits: count ceiling and full table
    for (int i = 0; i < 4; i++) do_ins(0, 0, 16'h1000 + i * 16, 0);
    do_ins(1, 3, 16'h2000, 0);
    do_ins(1, 4, 16'h2010, 0);
    do_ins(1, 0, 16'h3000, 0, 0);   // R2 count at MAX_OUT
    do_ins(0, 1, 16'h1040, 0);      // R5 table full -> not ready
    for (int i = 0; i < 4; i++) do_cpl(0, 16'h1000 + i * 16);
    do_cpl(1, 16'h2000);
    do_cpl(1, 16'h2010);
    do_cpl(0, 16'h3000);

    // random traffic over a small line pool
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      int addr = ($urandom_range(0, 7) + 16'h50) * 16 + $urandom_range(0, 15);
      int t = $urandom_range(0, 1);
      if (op <= 4) do_ins(t, $urandom_range(0, 7), addr, ($urandom_range(0, 3) == 0));
      else if (op <= 7) do_cpl($urandom_range(0, 1), addr);
      else if (op == 8) do_ts(t, addr, $urandom_range(0, 1), $urandom_range(0, 1));
      else idle(1);
    end
    finish_run();
  end
endmodule